// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of the cache line fills that a non-blocking cache has in flight. Every occupied entry stands for one line being fetched and holds a short queue of the requests that wait for that line. Each queued request carries an id, a read/write flag, a word offset and write data. The lookup stage offers each miss on a single port. In the same cycle the block answers with one of four outcomes: a new entry was taken, the miss was merged into an entry for the same line, the miss was refused because every entry is in use, or it was refused because the matching entry's queue is full.

A fetch port hands one line request per entry to memory and holds it while memory applies back pressure. When memory returns a line, the fill is matched by line address to an entry whose fetch has been sent. That entry then drains its waiting requests onto a replay output, one per cycle and in the order they arrived. The entry frees itself after its last request. Data storage and victim choice belong to the cache around this block.

Top module: `mshr_file`

## Requirements
- R1: A miss whose line matches no occupied entry, while a free entry exists, is accepted as primary. `miss_accept`=1 and `miss_is_secondary`=0. It takes the lowest-numbered free entry, and its own request becomes that entry's first queued target.
- R2: A miss whose line matches an occupied entry with fewer than TGT_DEPTH targets is accepted as secondary. `miss_accept`=1 and `miss_is_secondary`=1. It is appended to that entry and takes no new entry, so it is accepted even when every entry is occupied.
- R3: A miss whose line matches an entry that already holds TGT_DEPTH targets is refused. `miss_accept`=0 and `stall_tgt_full`=1.
- R4: A miss whose line matches no entry while all ENTRIES entries are occupied is refused. `miss_accept`=0 and `stall_file_full`=1. At most one of `miss_accept`, `stall_tgt_full` and `stall_file_full` is high in any cycle.
- R5: Every allocated entry requests exactly one line fetch on `issue_valid`/`issue_line`, and it is never fetched again. The lowest-numbered entry waiting for a fetch goes first. While `issue_ready` is low, `issue_valid` stays high and `issue_line` stays unchanged.
- R6: A fill (`fill_valid` with `fill_line`) that matches an entry whose fetch has been sent makes that entry replay its targets. Replay starts in the cycle after the fill, gives one target per cycle in arrival order, and shows the entry's line on `replay_line`.
- R7: The entry becomes free in the cycle its last target is replayed. A later miss to the same line is then primary.
- R8: A fill whose line matches no entry whose fetch has been sent is ignored and produces no replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss is offered this cycle |
| miss_line | input | 26 | Line address of the miss |
| miss_id | input | 4 | Requester id |
| miss_write | input | 1 | 1 for a write, 0 for a read |
| miss_off | input | 3 | Word offset within the line |
| miss_wdata | input | 32 | Write data |
| miss_accept | output | 1 | The miss was taken (primary or secondary) |
| miss_is_secondary | output | 1 | The miss line matches an occupied entry |
| stall_file_full | output | 1 | Refused: no match and no free entry |
| stall_tgt_full | output | 1 | Refused: matching entry's target queue is full |
| issue_valid | output | 1 | A line fetch is requested |
| issue_line | output | 26 | Line address to fetch |
| issue_ready | input | 1 | Memory takes the fetch; low means back pressure |
| fill_valid | input | 1 | Memory returns a line |
| fill_line | input | 26 | Line address of the returned line |
| replay_valid | output | 1 | A waiting target is released this cycle |
| replay_line | output | 26 | Line of the released target |
| replay_id | output | 4 | Requester id of the released target |
| replay_write | output | 1 | Read/write flag of the released target |
| replay_off | output | 3 | Word offset of the released target |
| replay_wdata | output | 32 | Write data of the released target |

## Verification
The bench fills one line's queue to its limit and then offers one more miss to that line. A design that counts queue depth off by one would accept that miss or refuse one miss too early. It then occupies every entry and offers one new line and one merge. A design that blocks merges when the file is full, or that mixes up the two stall causes, shows the wrong flag. Fetch requests are held under back pressure and then released, so a design that drops, repeats or reorders fetches is caught. Replay items are compared against a queue of expected requests in arrival order. The bench also checks that draining takes exactly one cycle per target, that a fill for an unknown line replays nothing, and that a drained line misses as primary again.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

    localparam int LINE_W = 26;
    localparam int ID_W   = 4;
    localparam int OFF_W  = 3;
    localparam int DATA_W = 32;

    typedef logic [LINE_W-1:0] line_t;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              write;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] wdata;
    } target_t;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PEND  = 2'd2,
        ST_DRAIN = 2'd3
    } ent_state_e;

    function automatic int idx_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mshr_pick.sv
module mshr_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mshr_lookup.sv
module mshr_lookup
    import mshr_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  occupied,
    input  line_t         ent_line [N],
    input  line_t         probe_line,
    output logic          hit,
    output logic [IW-1:0] hit_idx
);
    logic [N-1:0] match;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign match[g] = occupied[g] && (ent_line[g] == probe_line);
        end
    endgenerate

    mshr_pick #(.N(N)) u_enc (
        .req (match),
        .any (hit),
        .idx (hit_idx)
    );
endmodule

// File: rtl/mshr_entry.sv
module mshr_entry
    import mshr_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc,
    input  line_t         alloc_line,
    input  logic          push,
    input  target_t       push_tgt,
    input  logic          issued,
    input  logic          fill_hit,
    input  logic          pop,
    output ent_state_e    state,
    output line_t         line,
    output logic [CW-1:0] count,
    output target_t       head
);
    target_t       slots [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;

    assign head = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_FREE;
            line   <= '0;
            count  <= '0;
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else begin
            unique case (state)
                ST_FREE: if (alloc) begin
                    state <= ST_WAIT;
                    line  <= alloc_line;
                end
                ST_WAIT:  if (issued)   state <= ST_PEND;
                ST_PEND:  if (fill_hit) state <= ST_DRAIN;
                ST_DRAIN: if (pop && !push && count == CW'(1)) state <= ST_FREE;
                default:  state <= ST_FREE;
            endcase
            if (push) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
            end
            count <= count + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_tgt;
    end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
    import mshr_pkg::*;
#(
    parameter int ENTRIES   = 4,
    parameter int TGT_DEPTH = 4,
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CW = $clog2(TGT_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [LINE_W-1:0] miss_line,
    input  logic [ID_W-1:0]   miss_id,
    input  logic              miss_write,
    input  logic [OFF_W-1:0]  miss_off,
    input  logic [DATA_W-1:0] miss_wdata,
    output logic              miss_accept,
    output logic              miss_is_secondary,
    output logic              stall_file_full,
    output logic              stall_tgt_full,
    output logic              issue_valid,
    output logic [LINE_W-1:0] issue_line,
    input  logic              issue_ready,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_line,
    output logic              replay_valid,
    output logic [LINE_W-1:0] replay_line,
    output logic [ID_W-1:0]   replay_id,
    output logic              replay_write,
    output logic [OFF_W-1:0]  replay_off,
    output logic [DATA_W-1:0] replay_wdata
);
    ent_state_e   ent_state [ENTRIES];
    line_t        ent_line  [ENTRIES];
    logic [CW-1:0] ent_cnt  [ENTRIES];
    target_t      ent_head  [ENTRIES];

    logic [ENTRIES-1:0] occupied, free_vec, wait_vec, drain_vec;
    logic               hit, free_any, wait_any, drain_any;
    logic [IW-1:0]      hit_idx, free_idx, wait_idx, drain_idx;
    logic               room_left;
    target_t            in_tgt;

    // Fetch selection is held while memory applies back pressure.
    logic               held;
    logic [IW-1:0]      held_idx;
    logic [IW-1:0]      issue_idx;

    assign in_tgt = '{id: miss_id, write: miss_write, off: miss_off, wdata: miss_wdata};

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_vec
            assign occupied[g]  = (ent_state[g] != ST_FREE);
            assign free_vec[g]  = (ent_state[g] == ST_FREE);
            assign wait_vec[g]  = (ent_state[g] == ST_WAIT);
            assign drain_vec[g] = (ent_state[g] == ST_DRAIN);
        end
    endgenerate

    mshr_lookup #(.N(ENTRIES)) u_lookup (
        .occupied   (occupied),
        .ent_line   (ent_line),
        .probe_line (miss_line),
        .hit        (hit),
        .hit_idx    (hit_idx)
    );

    mshr_pick #(.N(ENTRIES)) u_pick_free (
        .req (free_vec), .any (free_any), .idx (free_idx)
    );

    mshr_pick #(.N(ENTRIES)) u_pick_wait (
        .req (wait_vec), .any (wait_any), .idx (wait_idx)
    );

    mshr_pick #(.N(ENTRIES)) u_pick_drain (
        .req (drain_vec), .any (drain_any), .idx (drain_idx)
    );

    assign room_left         = (32'(ent_cnt[hit_idx]) < TGT_DEPTH);
    assign miss_is_secondary = miss_valid && hit;
    assign miss_accept       = miss_valid && (hit ? room_left : free_any);
    assign stall_tgt_full    = miss_valid && hit && !room_left;
    assign stall_file_full   = miss_valid && !hit && !free_any;

    assign issue_idx   = held ? held_idx : wait_idx;
    assign issue_valid = held || wait_any;
    assign issue_line  = ent_line[issue_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            held     <= 1'b0;
            held_idx <= '0;
        end else begin
            held     <= issue_valid && !issue_ready;
            held_idx <= issue_idx;
        end
    end

    generate
        for (g = 0; g < ENTRIES; g++) begin : g_ent
            logic do_alloc, do_push, do_issue, do_fill, do_pop;
            assign do_alloc = miss_accept && !hit && (free_idx == IW'(g));
            assign do_push  = miss_accept && (hit ? (hit_idx == IW'(g)) : (free_idx == IW'(g)));
            assign do_issue = issue_valid && issue_ready && (issue_idx == IW'(g));
            assign do_fill  = fill_valid && (ent_state[g] == ST_PEND) && (ent_line[g] == fill_line);
            assign do_pop   = drain_any && (drain_idx == IW'(g));

            mshr_entry #(.DEPTH(TGT_DEPTH)) u_entry (
                .clk        (clk),
                .rst        (rst),
                .alloc      (do_alloc),
                .alloc_line (miss_line),
                .push       (do_push),
                .push_tgt   (in_tgt),
                .issued     (do_issue),
                .fill_hit   (do_fill),
                .pop        (do_pop),
                .state      (ent_state[g]),
                .line       (ent_line[g]),
                .count      (ent_cnt[g]),
                .head       (ent_head[g])
            );
        end
    endgenerate

    assign replay_valid = drain_any;
    assign replay_line  = ent_line[drain_idx];
    assign replay_id    = ent_head[drain_idx].id;
    assign replay_write = ent_head[drain_idx].write;
    assign replay_off   = ent_head[drain_idx].off;
    assign replay_wdata = ent_head[drain_idx].wdata;
endmodule

// File: rtl/mshr_file_checker.sv
module mshr_file_checker
    import mshr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              miss_valid,
    input logic              miss_accept,
    input logic              miss_is_secondary,
    input logic              stall_file_full,
    input logic              stall_tgt_full,
    input logic              issue_valid,
    input logic [LINE_W-1:0] issue_line,
    input logic              issue_ready,
    input logic              fill_valid,
    input logic              replay_valid
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({miss_accept, stall_tgt_full, stall_file_full})); // R4

    AST_MERGE_NEVER_FILE_STALL: assert property (@(posedge clk) disable iff (rst)
        miss_is_secondary |-> !stall_file_full); // R2

    AST_TGT_STALL_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        stall_tgt_full |-> miss_is_secondary); // R3

    AST_ISSUE_HELD: assert property (@(posedge clk) disable iff (rst)
        issue_valid && !issue_ready |=> issue_valid && $stable(issue_line)); // R5

    AST_REPLAY_NEEDS_FILL: assert property (@(posedge clk) disable iff (rst)
        $rose(replay_valid) |-> $past(fill_valid)); // R6

    AST_IDLE_NO_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !miss_valid |-> !miss_accept && !stall_file_full && !stall_tgt_full); // R1
endmodule

bind mshr_file mshr_file_checker u_chk (.*);

// File: tb/mshr_file_bench.sv
module mshr_file_bench;
    import mshr_pkg::*;

    localparam int N = 4;
    localparam int D = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst;
    logic              miss_valid;
    logic [LINE_W-1:0] miss_line;
    logic [ID_W-1:0]   miss_id;
    logic              miss_write;
    logic [OFF_W-1:0]  miss_off;
    logic [DATA_W-1:0] miss_wdata;
    logic              miss_accept, miss_is_secondary, stall_file_full, stall_tgt_full;
    logic              issue_valid;
    logic [LINE_W-1:0] issue_line;
    logic              issue_ready;
    logic              fill_valid;
    logic [LINE_W-1:0] fill_line;
    logic              replay_valid;
    logic [LINE_W-1:0] replay_line;
    logic [ID_W-1:0]   replay_id;
    logic              replay_write;
    logic [OFF_W-1:0]  replay_off;
    logic [DATA_W-1:0] replay_wdata;

    mshr_file #(.ENTRIES(N), .TGT_DEPTH(D)) u_mshr_file (.*);

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [65:0] exp_q [$];
    logic [39:0] model [8][$];

    function automatic line_t ln(int k);
        return line_t'(32'h100 + k);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // exp = {accept, secondary, tgt_full, file_full}
    task automatic do_miss(int k, logic [3:0] id, logic w, logic [2:0] off, logic [3:0] exp, string req);
        logic [3:0] got;
        @(negedge clk);
        miss_valid = 1'b1;
        miss_line  = ln(k);
        miss_id    = id;
        miss_write = w;
        miss_off   = off;
        miss_wdata = 32'hC0DE_0000 + 32'(id) * 32'h111;
        #1;
        got = {miss_accept, miss_is_secondary, stall_tgt_full, stall_file_full};
        chk(got == exp, req, "miss outcome", 128'(got), 128'(exp));
        if (miss_accept) model[k].push_back({miss_id, miss_write, miss_off, miss_wdata});
        @(posedge clk);
        #1 miss_valid = 1'b0;
    endtask

    task automatic do_fill(int k);
        int n;
        n = model[k].size();
        for (int j = 0; j < n; j++) exp_q.push_back({ln(k), model[k][j]});
        model[k].delete();
        @(negedge clk);
        fill_valid = 1'b1;
        fill_line  = ln(k);
        @(posedge clk);
        #1 fill_valid = 1'b0;
        repeat (n) @(negedge clk);
        @(negedge clk);
        #1;
        chk(!replay_valid && exp_q.size() == 0, "R6", "one replay per cycle then stop",
            128'({replay_valid, 8'(exp_q.size())}), 128'(0));
    endtask

    // Scoreboard monitor: pops expected targets as the design replays them.
    always @(negedge clk) begin
        logic [65:0] got;
        logic [65:0] want;
        if (!rst && replay_valid) begin
            got = {replay_line, replay_id, replay_write, replay_off, replay_wdata};
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6/R8", "replay with nothing expected", 128'(got), 128'(0));
            end else begin
                want = exp_q.pop_front();
                chk(got == want, "R6", "replayed target", 128'(got), 128'(want));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        line_t seen [$];
        rst = 1'b1; miss_valid = 0; miss_line = '0; miss_id = '0; miss_write = 0;
        miss_off = '0; miss_wdata = '0; issue_ready = 0; fill_valid = 0; fill_line = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        chk(!issue_valid, "R5", "no fetch after reset", 128'(issue_valid), 0);
        chk(!replay_valid, "R6", "no replay after reset", 128'(replay_valid), 0);
        chk(!miss_accept && !stall_file_full && !stall_tgt_full, "R1", "idle outcome after reset",
            128'({miss_accept, stall_file_full, stall_tgt_full}), 0);

        // Line 0: primary then merges up to the queue limit, then one too many.
        do_miss(0, 4'd1, 1'b0, 3'd2, 4'b1000, "R1");
        do_miss(0, 4'd2, 1'b1, 3'd5, 4'b1100, "R2");
        do_miss(0, 4'd3, 1'b0, 3'd0, 4'b1100, "R2");
        do_miss(0, 4'd4, 1'b1, 3'd7, 4'b1100, "R2");
        do_miss(0, 4'd5, 1'b0, 3'd1, 4'b0110, "R3");

        // Back pressure holds the fetch.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(issue_valid && issue_line == ln(0), "R5", "fetch held under back pressure",
                128'({issue_valid, issue_line}), 128'({1'b1, ln(0)}));
        end

        // Fill the file, then a new line and a merge while full.
        do_miss(1, 4'd6, 1'b0, 3'd3, 4'b1000, "R1");
        do_miss(2, 4'd7, 1'b1, 3'd4, 4'b1000, "R1");
        do_miss(3, 4'd8, 1'b0, 3'd6, 4'b1000, "R1");
        do_miss(4, 4'd9, 1'b0, 3'd0, 4'b0001, "R4");
        do_miss(1, 4'd10, 1'b1, 3'd2, 4'b1100, "R2");

        // Release back pressure: fetches in entry order, each once.
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            issue_ready = 1'b1;
            #1;
            if (issue_valid) seen.push_back(issue_line);
        end
        chk(seen.size() == 4, "R5", "fetch count", 128'(seen.size()), 128'(4));
        for (int i = 0; i < 4 && i < seen.size(); i++)
            chk(seen[i] == ln(i), "R5", "fetch order", 128'(seen[i]), 128'(ln(i)));

        // Fill for an unknown line is ignored.
        @(negedge clk);
        fill_valid = 1'b1;
        fill_line  = ln(4);
        @(posedge clk);
        #1 fill_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(!replay_valid, "R8", "no replay for unmatched fill", 128'(replay_valid), 0);
        end

        do_fill(2);
        do_fill(0);

        // Freed entries: the drained line misses as primary again.
        do_miss(0, 4'd11, 1'b0, 3'd1, 4'b1000, "R7");
        do_miss(4, 4'd12, 1'b1, 3'd3, 4'b1000, "R7");

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule